// File: doc/BRIEF.md
# Serial Register Front End for a Multi-Channel Sigma-Delta Converter

This block is the serial slave that gives a host access to the register file of a multi-channel sigma-delta converter. The serial clock idles high. The host changes DIN on falling SCLK edges and samples DOUT on rising edges. The block runs on its own system clock. It synchronises SCLK, DIN and the active-low select, and it detects SCLK edges by oversampling them, so SCLK has to be several times slower than the system clock.

Each frame opens with an 8-bit command byte that selects a read or a write and names a register. The length of the data phase that follows depends on which register is addressed. After the data phase the next byte is a new command byte, with no need to raise the select.

The block holds the register storage, the identity and status registers, the data-ready output, a power-on flag, and an optional status byte appended to data reads. It also resets itself when it sees a long run of ones on DIN. Conversion results reach it on a parallel strobe port.

Top module: `sdreg_spi_slave`

## Requirements
- R1: Bits are sent and received MSB first. DIN is captured on rising SCLK edges while cs_n is low. DOUT changes only after a falling SCLK edge and holds 0 outside read data phases.
- R2: In the command byte, bit 6 = 1 selects a read and bit 6 = 0 a write, bits 5:0 hold the address and bit 7 is ignored. The data phase is 1 byte for addresses 0x00, 0x05 and 0x08. It is 2 bytes for 0x01, 0x04 and 0x09–0x20, and 3 bytes for 0x02, 0x03, 0x06, 0x07 and 0x21–0x3F. After the data phase, the next byte under the same select is a command byte.
- R3: A write to any address in 0x01–0x38 other than 0x02 and 0x05 stores the low 8×width bits. A later read returns that value.
- R4: Writes to 0x00, 0x02, 0x05 and to addresses above 0x38 change nothing. A read above 0x38 returns three zero bytes.
- R5: A read of address 0x00 returns a status byte. Bit 7 is rdy_n, bit 4 is the power-on flag, bits 3:0 are the channel of the latest result, and bits 6:5 are 0.
- R6: Address 0x05 reads as {DEV_ID, SI_REV}, with the ID in bits 7:4 and a non-zero revision in bits 3:0.
- R7: A conv_valid pulse latches conv_data and conv_chan and drives rdy_n low one clock later. rdy_n returns high once the command byte of a read of 0x02 has been decoded. Address 0x02 reads back the latched 24-bit result.
- R8: When bit 10 of register 0x01 is set, a read of 0x02 returns 4 bytes: the 24-bit result followed by the status byte of R5.
- R9: 64 consecutive rising SCLK edges with DIN high while cs_n is low cause a soft reset. All registers return to zero, the latched result and channel clear, rdy_n goes high and the power-on flag sets. A run of 63 ones followed by a zero has no effect.
- R10: The power-on flag is set by either reset and clears SETTLE_CYCLES clocks later. Once clear, it stays clear until the next reset.
- R11: Raising cs_n abandons any partial frame. The next frame starts with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| rdy_n | output | 1 | Active-low data ready |
| conv_valid | input | 1 | One-cycle strobe for a new result |
| conv_data | input | 24 | Conversion result |
| conv_chan | input | 4 | Channel that produced the result |

## Verification
rdy_n is registered, so it is due one clock after conv_valid. The bench samples it on the following falling clock edge. DOUT trails a falling SCLK edge by about three system clocks of synchronisation. The bench therefore holds each SCLK half-period for six clocks and reads DOUT just before it raises SCLK. After any reset, the store spends 64 clocks clearing before it answers. The bench waits out that window. It reads the power-on flag once well inside the SETTLE_CYCLES window and once well after it, so no check lands close to the edge of that window.

// File: rtl/sdreg_pkg.sv
package sdreg_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 24;
  localparam int CHAN_W     = 4;
  localparam int APPEND_BIT = 10;
  localparam logic [ADDR_W-1:0] LAST_ADDR = 6'h38;
  localparam logic [ADDR_W-1:0] A_STATUS  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h01;
  localparam logic [ADDR_W-1:0] A_DATA    = 6'h02;
  localparam logic [ADDR_W-1:0] A_IDENT   = 6'h05;

  typedef enum logic [1:0] {PH_CMD, PH_LOAD, PH_WDATA, PH_RDATA} phase_t;

  // data phase length in bytes for an address
  function automatic logic [2:0] reg_bytes(input logic [ADDR_W-1:0] a);
    if (a == 6'd0 || a == 6'd5 || a == 6'd8) return 3'd1;
    if (a == 6'd1 || a == 6'd4)               return 3'd2;
    if (a <= 6'd8)                            return 3'd3;
    if (a <= 6'h20)                           return 3'd2;
    return 3'd3;
  endfunction

  function automatic logic reg_writable(input logic [ADDR_W-1:0] a);
    return !(a == A_STATUS || a == A_DATA || a == A_IDENT) && (a <= LAST_ADDR);
  endfunction

  function automatic logic [DATA_W-1:0] byte_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 24'h0000FF;
      3'd2:    return 24'h00FFFF;
      default: return 24'hFFFFFF;
    endcase
  endfunction
endpackage

// File: rtl/sdreg_sync.sv
module sdreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic din_i,
  output logic rise_o,
  output logic fall_o,
  output logic act_o,
  output logic din_o
);
  localparam int W = 3 * STAGES;
  logic [W-1:0] chain;
  logic [2:0]   last;
  logic         sclk_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 3'b110;
        else     chain <= {sclk_i, csn_i, din_i};
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{3'b110}};
        else     chain <= {chain[W-4:0], sclk_i, csn_i, din_i};
      end
    end
  endgenerate

  assign last = chain[W-1 -: 3];

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b1;
    else     sclk_prev <= last[2];
  end

  assign rise_o = last[2] & ~sclk_prev;
  assign fall_o = ~last[2] & sclk_prev;
  assign act_o  = ~last[1];
  assign din_o  = last[0];
endmodule

// File: rtl/sdreg_ones_det.sv
module sdreg_ones_det #(
  parameter int RUN_LEN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic rise,
  input  logic din,
  output logic hit_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (!act) begin
        cnt <= '0;
      end else if (rise) begin
        if (!din) begin
          cnt <= '0;
        end else if (cnt == CW'(RUN_LEN - 1)) begin
          cnt   <= '0;
          hit_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: the reset request is a single-cycle pulse
  p_hit_single_r9: assert property (@(posedge clk) disable iff (rst) hit_o |=> !hit_o);
endmodule

// File: rtl/sdreg_store.sv
module sdreg_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sdreg_spi_slave.sv
module sdreg_spi_slave import sdreg_pkg::*; #(
  parameter int          SYNC_STAGES   = 2,
  parameter int          RESET_RUN     = 64,
  parameter int          SETTLE_CYCLES = 512,
  parameter logic [3:0]  DEV_ID        = 4'h1,
  parameter logic [3:0]  SI_REV        = 4'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              rdy_n,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CHAN_W-1:0] conv_chan
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int POR_LEN = (SETTLE_CYCLES > DEPTH) ? SETTLE_CYCLES : DEPTH;
  localparam int SCW     = $clog2(POR_LEN + 1);
  localparam int OUT_W   = DATA_W + 8;

  logic rise, fall, act, din_s, srst, lrst;
  logic spi_rise, spi_fall;

  sdreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(cs_n), .din_i(din),
    .rise_o(rise), .fall_o(fall), .act_o(act), .din_o(din_s)
  );

  sdreg_ones_det #(.RUN_LEN(RESET_RUN)) u_det (
    .clk(clk), .rst(rst), .act(act), .rise(rise), .din(din_s), .hit_o(srst)
  );

  assign lrst = rst | srst;

  // power-on window and clearing sweep
  logic [SCW-1:0] init_cnt;
  logic           por_q, clearing;

  always_ff @(posedge clk) begin
    if (lrst) begin
      init_cnt <= '0;
      por_q    <= 1'b1;
    end else if (por_q) begin
      if (init_cnt == SCW'(POR_LEN - 1)) por_q <= 1'b0;
      else                                init_cnt <= init_cnt + 1'b1;
    end
  end

  assign clearing = por_q && (init_cnt < SCW'(DEPTH));
  assign spi_rise = rise & act & ~clearing;
  assign spi_fall = fall & act & ~clearing;

  // framing state
  phase_t              phase;
  logic [5:0]          bitcnt, nbits;
  logic [DATA_W-2:0]   in_sh;
  logic [ADDR_W-1:0]   cmd_addr;
  logic [OUT_W-1:0]    out_sh, ld_word;
  logic [5:0]          ld_bits;
  logic                dout_q, ctrl_app, rdy_q;
  logic [DATA_W-1:0]   data_q, mem_q, wr_val, ld_val;
  logic [CHAN_W-1:0]   chan_q;
  logic [7:0]          status8;
  logic [2:0]          rd_n;
  logic                wr_fire, wr_ok, ld_append;
  logic [ADDR_W-1:0]   cmd_next_addr;

  assign cmd_next_addr = {in_sh[ADDR_W-2:0], din_s};
  assign wr_fire = spi_rise && (phase == PH_WDATA) && (bitcnt == nbits - 6'd1);
  assign wr_val  = {in_sh, din_s} & byte_mask(reg_bytes(cmd_addr));
  assign wr_ok   = wr_fire && reg_writable(cmd_addr);

  sdreg_store #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_store (
    .clk(clk),
    .we(clearing | wr_ok),
    .waddr(clearing ? init_cnt[ADDR_W-1:0] : cmd_addr),
    .wdata(clearing ? '0 : wr_val),
    .raddr(cmd_next_addr),
    .rdata(mem_q)
  );

  // read word assembly, used in the load cycle
  assign status8   = {rdy_q, 2'b00, por_q, chan_q};
  assign rd_n      = reg_bytes(cmd_addr);
  assign ld_append = (cmd_addr == A_DATA) && ctrl_app;

  always_comb begin
    if (cmd_addr == A_STATUS)      ld_val = {16'h0000, status8};
    else if (cmd_addr == A_DATA)   ld_val = data_q;
    else if (cmd_addr == A_IDENT)  ld_val = {16'h0000, DEV_ID, SI_REV};
    else if (cmd_addr > LAST_ADDR) ld_val = '0;
    else                           ld_val = mem_q & byte_mask(rd_n);

    if (ld_append) begin
      ld_word = {ld_val, status8};
      ld_bits = 6'd32;
    end else begin
      case (rd_n)
        3'd1:    ld_word = {ld_val[7:0],  24'h000000};
        3'd2:    ld_word = {ld_val[15:0], 16'h0000};
        default: ld_word = {ld_val,       8'h00};
      endcase
      ld_bits = {rd_n, 3'b000};
    end
  end

  always_ff @(posedge clk) begin
    if (lrst) begin
      phase    <= PH_CMD;
      bitcnt   <= '0;
      nbits    <= 6'd8;
      in_sh    <= '0;
      cmd_addr <= '0;
      out_sh   <= '0;
      dout_q   <= 1'b0;
    end else if (!act || clearing) begin
      phase  <= PH_CMD;
      bitcnt <= '0;
      dout_q <= 1'b0;
    end else begin
      if (spi_fall) begin
        if (phase == PH_RDATA) begin
          dout_q <= out_sh[OUT_W-1];
          out_sh <= {out_sh[OUT_W-2:0], 1'b0};
        end else begin
          dout_q <= 1'b0;
        end
      end
      case (phase)
        PH_CMD: if (spi_rise) begin
          if (bitcnt == 6'd7) begin
            bitcnt   <= '0;
            cmd_addr <= cmd_next_addr;
            in_sh    <= '0;
            if (in_sh[5]) begin
              phase <= PH_LOAD;
            end else begin
              phase <= PH_WDATA;
              nbits <= {reg_bytes(cmd_next_addr), 3'b000};
            end
          end else begin
            bitcnt <= bitcnt + 6'd1;
            in_sh  <= {in_sh[DATA_W-3:0], din_s};
          end
        end
        PH_LOAD: begin
          out_sh <= ld_word;
          nbits  <= ld_bits;
          phase  <= PH_RDATA;
        end
        PH_WDATA: if (spi_rise) begin
          in_sh <= {in_sh[DATA_W-3:0], din_s};
          if (wr_fire) begin
            bitcnt <= '0;
            phase  <= PH_CMD;
          end else begin
            bitcnt <= bitcnt + 6'd1;
          end
        end
        PH_RDATA: if (spi_rise) begin
          if (bitcnt == nbits - 6'd1) begin
            bitcnt <= '0;
            phase  <= PH_CMD;
          end else begin
            bitcnt <= bitcnt + 6'd1;
          end
        end
        default: phase <= PH_CMD;
      endcase
    end
  end

  // control shadow: status append enable
  always_ff @(posedge clk) begin
    if (lrst)                               ctrl_app <= 1'b0;
    else if (wr_ok && cmd_addr == A_CTRL)   ctrl_app <= wr_val[APPEND_BIT];
  end

  // result latch and data-ready
  always_ff @(posedge clk) begin
    if (lrst) begin
      rdy_q  <= 1'b1;
      data_q <= '0;
      chan_q <= '0;
    end else if (conv_valid) begin
      rdy_q  <= 1'b0;
      data_q <= conv_data;
      chan_q <= conv_chan;
    end else if (phase == PH_LOAD && cmd_addr == A_DATA) begin
      rdy_q <= 1'b1;
    end
  end

  assign dout  = dout_q;
  assign rdy_n = rdy_q;

  // R7: ready falls one clock after a result strobe
  p_rdy_low_r7: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !srst) |=> !rdy_n);
  // R7: ready rises when a data read is decoded
  p_rdy_high_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && cmd_addr == A_DATA && !conv_valid && !srst) |=> rdy_n);
  // R10: soft reset sets the power-on flag
  p_por_set_r10: assert property (@(posedge clk) disable iff (rst) srst |=> por_q);
  // R10: once clear, the flag stays clear until a reset
  p_por_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!por_q && !srst) |=> !por_q);
  // R1: DOUT only moves after a falling SCLK edge while selected
  p_dout_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (act && !clearing && !srst && !spi_fall) |=> $stable(dout));
  // R2: read data phases are whole bytes of one to four
  p_nbits_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RDATA) |-> (nbits == 6'd8 || nbits == 6'd16 || nbits == 6'd24 || nbits == 6'd32));
  // R8: append enable moves only through a control write
  p_ctrl_only_r8: assert property (@(posedge clk) disable iff (rst)
    (!wr_ok && !srst) |=> $stable(ctrl_app));
endmodule

// File: tb/sdreg_spi_slave_test.sv
`timescale 1ns/1ps
module sdreg_spi_slave_test;
  localparam int HALF = 6;
  localparam logic [7:0] ID_EXP = 8'h12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic din = 1'b0;
  logic conv_valid = 1'b0;
  logic [23:0] conv_data = '0;
  logic [3:0]  conv_chan = '0;
  wire dout, rdy_n;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  sdreg_spi_slave uut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout),
    .rdy_n(rdy_n), .conv_valid(conv_valid), .conv_data(conv_data), .conv_chan(conv_chan)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0;
      din  = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = dout;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    din  = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input int n, output logic [31:0] v);
    logic [7:0] r;
    xfer({2'b01, a}, r);
    v = '0;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      v = {v[23:0], r};
    end
  endtask

  task automatic wr(input logic [5:0] a, input int n, input logic [23:0] val);
    logic [7:0] r;
    xfer({2'b00, a}, r);
    for (int i = n - 1; i >= 0; i--) xfer(val[8*i +: 8], r);
  endtask

  task automatic rd_tx(input logic [5:0] a, input int n, output logic [31:0] v);
    sel();
    rd(a, n, v);
    desel();
  endtask

  task automatic pulse_conv(input logic [23:0] d, input logic [3:0] c);
    @(negedge clk);
    conv_valid = 1'b1;
    conv_data  = d;
    conv_chan  = c;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  function automatic int nb(input int a);
    if (a == 0 || a == 5 || a == 8) return 1;
    if (a == 1 || a == 4) return 2;
    if (a <= 8) return 3;
    if (a <= 32) return 2;
    return 3;
  endfunction

  function automatic logic [23:0] pat(input int a);
    logic [5:0] s;
    logic [23:0] p;
    s = 6'(a);
    p = {2'b10, s, 2'b01, ~s, 2'b11, s ^ 6'h2A};
    if (a == 1) p[10] = 1'b0;
    return p;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    vectors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [7:0]  r;
    repeat (5) @(negedge clk);
    chk("reset R7 rdy_n", {31'b0, rdy_n}, 32'd1);
    chk("reset R1 dout", {31'b0, dout}, 32'd0);
    rst = 1'b0;
    repeat (70) @(negedge clk);

    // R10/R5: power-on flag visible early
    rd_tx(6'h00, 1, v);
    chk("R10 por set after reset", v, 32'h90);
    repeat (600) @(negedge clk);
    rd_tx(6'h00, 1, v);
    chk("R10 por cleared", v, 32'h80);
    rd_tx(6'h05, 1, v);
    chk("R6 identity", v, {24'h0, ID_EXP});

    // R2/R3/R4 sweep of every address
    for (int a = 0; a < 64; a++) begin
      logic [31:0] e;
      int n;
      n = nb(a);
      sel();
      wr(6'(a), n, pat(a));
      rd(6'h05, 1, v);
      chk($sformatf("R2 framing after write a=%0d", a), v, {24'h0, ID_EXP});
      desel();
      sel();
      rd(6'(a), n, v);
      if (a == 0)       e = 32'h80;
      else if (a == 2)  e = 32'h0;
      else if (a == 5)  e = {24'h0, ID_EXP};
      else if (a > 56)  e = 32'h0;
      else              e = {8'h0, pat(a)} & ((32'd1 << (8 * n)) - 32'd1);
      chk($sformatf("R3/R4 readback a=%0d", a), v, e);
      rd(6'h05, 1, v);
      chk($sformatf("R2 framing after read a=%0d", a), v, {24'h0, ID_EXP});
      desel();
    end

    // R7: result latch and ready
    pulse_conv(24'hA5C3E1, 4'd11);
    chk("R7 rdy_n low", {31'b0, rdy_n}, 32'd0);
    rd_tx(6'h00, 1, v);
    chk("R5 status with pending result", v, 32'h0B);
    rd_tx(6'h02, 3, v);
    chk("R7 data read", v, 32'hA5C3E1);
    chk("R7 rdy_n high after read", {31'b0, rdy_n}, 32'd1);

    // R8: status append
    sel(); wr(6'h01, 2, 24'h000400); desel();
    pulse_conv(24'h13579B, 4'd6);
    sel();
    rd(6'h02, 4, v);
    chk("R8 appended read", v, 32'h13579B06);
    rd(6'h05, 1, v);
    chk("R8 framing after 4-byte read", v, {24'h0, ID_EXP});
    desel();
    sel(); wr(6'h01, 2, 24'h000000); desel();
    rd_tx(6'h02, 3, v);
    chk("R8 append off", v, 32'h13579B);

    // R11: aborted frame
    sel();
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; din = i[0];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    desel();
    rd_tx(6'h05, 1, v);
    chk("R11 frame after abort", v, {24'h0, ID_EXP});

    // R9: 63 ones then a zero has no effect
    sel(); wr(6'h09, 2, 24'h00BEEF); desel();
    sel();
    for (int i = 0; i < 7; i++) xfer(8'hFF, r);
    xfer(8'hFE, r);
    desel();
    rd_tx(6'h09, 2, v);
    chk("R9 63 ones keeps register", v, 32'hBEEF);
    rd_tx(6'h00, 1, v);
    chk("R9 63 ones keeps por clear", v, 32'h86);

    // R9: 64 ones resets everything
    pulse_conv(24'h777777, 4'd3);
    sel(); wr(6'h01, 2, 24'h001234); desel();
    sel();
    for (int i = 0; i < 8; i++) xfer(8'hFF, r);
    desel();
    chk("R9 rdy_n after soft reset", {31'b0, rdy_n}, 32'd1);
    repeat (70) @(negedge clk);
    rd_tx(6'h00, 1, v);
    chk("R9/R10 por set by soft reset", v, 32'h90);
    rd_tx(6'h09, 2, v);
    chk("R9 channel register cleared", v, 32'h0);
    rd_tx(6'h01, 2, v);
    chk("R9 control cleared", v, 32'h0);
    rd_tx(6'h02, 3, v);
    chk("R9 result cleared", v, 32'h0);
    repeat (600) @(negedge clk);
    rd_tx(6'h00, 1, v);
    chk("R10 por clears after soft reset", v, 32'h80);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule